// File: doc/BRIEF.md
# Cascadable Four-Bit Counter and Shift Register Slice

This block is one slice of a register that can count up or down, shift either way, load a preset word, clear, invert or hold. A three-bit operation code picks what the register does at each rising clock edge. The slice is meant to be tiled. Its active-low terminal-count output is combinational. It can feed the combined enable and serial input of the next slice up. A row of identical slices therefore forms a wider counter, or a longer shift-up chain, with no extra glue logic.

The register width is a parameter, with a default of four bits. An active-high master reset clears the register at once and does not wait for a clock edge. The slice drives the register value and its bitwise complement as outputs.

Top module: `cnt_slice`

## Requirements
- R1: Operation code 000 copies `preset` into `q` at the clock edge. While this code is applied, `tc_n` is 0.
- R2: Operation code 001 inverts every bit of `q` at the clock edge. While this code is applied, `tc_n` is 0.
- R3: Operation code 010 shifts toward bit 0. Each bit takes the bit above it, and the top bit takes `sin_dn`. While this code is applied, `tc_n` equals `sin_dn`.
- R4: Operation code 011 shifts toward the top bit. Each bit takes the bit below it, and bit 0 takes `cet_sin_n`. While this code is applied, `tc_n` equals the top bit of `q`.
- R5: Operation code 110 counts up and operation code 100 counts down. Both wrap modulo 2^W. A step happens only when `cep_n` and `cet_sin_n` are both 0.
- R6: In either count code, if `cep_n` or `cet_sin_n` is 1, then `q` keeps its value across the edge.
- R7: In count-up, `tc_n` is 0 exactly when `cet_sin_n` is 0 and `q` is all ones. In count-down, `tc_n` is 0 exactly when `cet_sin_n` is 0 and `q` is zero. In all other cases `tc_n` is 1.
- R8: Operation code 101 clears `q` to zero at the edge. Operation code 111 keeps `q` unchanged. In both codes `tc_n` is 1.
- R9: While `mreset` is 1, `q` is zero. The clear takes effect without a clock edge and overrides every other input.
- R10: `q_n` is always the bitwise complement of `q`.
- R11: Two slices can be chained by feeding the lower slice's `tc_n` into the upper slice's `cet_sin_n`. The pair then counts as one 2W-bit counter in both directions, including wrap at the slice boundary. In code 011 the pair acts as one 2W-bit shift-up register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| mreset | input | 1 | Asynchronous master clear, active high |
| mode | input | 3 | Operation code |
| preset | input | W | Parallel load word |
| cep_n | input | 1 | Count enable, active low |
| cet_sin_n | input | 1 | Count enable (active low) and shift-up serial input |
| sin_dn | input | 1 | Shift-down serial input |
| q | output | W | Register value |
| q_n | output | W | Complement of the register value |
| tc_n | output | 1 | Terminal count / cascade output, active low |

## Verification
The register outputs `q` and `q_n` change one rising edge after their inputs are applied. `tc_n` follows the operation code, the serial inputs and `q` within the same cycle. The bench changes inputs on the falling edge and checks `q` on the next falling edge, so exactly one register stage lies between stimulus and check. It checks `tc_n` one time unit after changing inputs, before any edge. The master reset is checked between clock edges, to show that the clear does not wait for a rising edge. In the cascade tests, the combined value is read only after the upper slice's enable has settled through the lower slice's `tc_n`.

// File: rtl/cnt_slice_pkg.sv
// Shared types for the counter/shift slice.
// Assumes: the numeric code of each operation is fixed, because
// neighbouring slices and the controller drive it as a raw 3-bit value.
package cnt_slice_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'b000,
        OP_INV   = 3'b001,
        OP_SHDN  = 3'b010,
        OP_SHUP  = 3'b011,
        OP_CDN   = 3'b100,
        OP_CLR   = 3'b101,
        OP_CUP   = 3'b110,
        OP_HOLD  = 3'b111
    } op_e;
endpackage

// File: rtl/cnt_slice_next.sv
// Next-state logic: picks the register value for the next edge from the
// operation code. Assumes W >= 2. It is purely combinational.
module cnt_slice_next
    import cnt_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  op_e          op,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] preset,
    input  logic         cep_n,
    input  logic         cet_n,
    input  logic         sin_dn,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] sh_up;
    logic [W-1:0] sh_dn;
    logic         step;

    // Shift networks: bit 0 enters from cet_n, the top bit enters from sin_dn.
    genvar i;
    for (i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_up_lo
            assign sh_up[i] = cet_n;
        end else begin : g_up_hi
            assign sh_up[i] = cur[i-1];
        end
        if (i == W-1) begin : g_dn_top
            assign sh_dn[i] = sin_dn;
        end else begin : g_dn_low
            assign sh_dn[i] = cur[i+1];
        end
    end

    // Counting is allowed only when both active-low enables are asserted.
    assign step = !cep_n && !cet_n;

    // Operation multiplexer.
    always_comb begin
        unique case (op)
            OP_LOAD: nxt = preset;
            OP_INV:  nxt = ~cur;
            OP_SHDN: nxt = sh_dn;
            OP_SHUP: nxt = sh_up;
            OP_CDN:  nxt = step ? cur - ONE : cur;
            OP_CLR:  nxt = '0;
            OP_CUP:  nxt = step ? cur + ONE : cur;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_slice_tc.sv
// Terminal-count / cascade output. Combinational from the current value,
// the operation code and both serial inputs. It carries no register, so that
// a chain of slices ripples its enable within one cycle.
module cnt_slice_tc
    import cnt_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  op_e          op,
    input  logic [W-1:0] cur,
    input  logic         cet_n,
    input  logic         sin_dn,
    output logic         tc_n
);
    logic at_top;
    logic at_zero;

    // Detect the terminal value for each count direction.
    assign at_top  = &cur;
    assign at_zero = ~|cur;

    // Select the terminal-count meaning for each operation.
    always_comb begin
        unique case (op)
            OP_LOAD: tc_n = 1'b0;
            OP_INV:  tc_n = 1'b0;
            OP_SHDN: tc_n = sin_dn;
            OP_SHUP: tc_n = cur[W-1];
            OP_CDN:  tc_n = cet_n || !at_zero;
            OP_CUP:  tc_n = cet_n || !at_top;
            default: tc_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/cnt_slice_reg.sv
// State register with an asynchronous active-high clear. The clear
// overrides the data input.
module cnt_slice_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the next value on the rising edge, or clear at once.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/cnt_slice.sv
// Top of the counter/shift slice. Joins the next-state logic, the register
// and the terminal-count logic, and drives the true and complement outputs.
// Assumes W >= 2 and that mode is stable around the rising clock edge.
module cnt_slice
    import cnt_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         mreset,
    input  logic [2:0]   mode,
    input  logic [W-1:0] preset,
    input  logic         cep_n,
    input  logic         cet_sin_n,
    input  logic         sin_dn,
    output logic [W-1:0] q,
    output logic [W-1:0] q_n,
    output logic         tc_n
);
    localparam int SW = W;

    op_e          op;
    logic [SW-1:0] nxt;
    logic [SW-1:0] cur;

    // Give the raw operation code its type.
    assign op = op_e'(mode);

    cnt_slice_next #(.W(SW)) u_next (
        .op(op), .cur(cur), .preset(preset), .cep_n(cep_n),
        .cet_n(cet_sin_n), .sin_dn(sin_dn), .nxt(nxt)
    );

    cnt_slice_reg #(.W(SW)) u_reg (
        .clk(clk), .clr(mreset), .d(nxt), .q(cur)
    );

    cnt_slice_tc #(.W(SW)) u_tc (
        .op(op), .cur(cur), .cet_n(cet_sin_n), .sin_dn(sin_dn), .tc_n(tc_n)
    );

    // Drive the register value and its complement.
    assign q   = cur;
    assign q_n = ~cur;
endmodule

// File: rtl/cnt_slice_chk.sv
// Property checker for cnt_slice. It is attached through bind and only
// observes the slice's ports.
module cnt_slice_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         mreset,
    input logic [2:0]   mode,
    input logic [W-1:0] preset,
    input logic         cep_n,
    input logic         cet_sin_n,
    input logic         sin_dn,
    input logic [W-1:0] q,
    input logic         tc_n
);
    p_load_r1: assert property (@(posedge clk) disable iff (mreset)
        mode == 3'b000 |=> q == $past(preset));

    p_invert_r2: assert property (@(posedge clk) disable iff (mreset)
        mode == 3'b001 |=> q == ~$past(q));

    p_shift_dn_r3: assert property (@(posedge clk) disable iff (mreset)
        mode == 3'b010 |=> q == {$past(sin_dn), $past(q[W-1:1])});

    p_shift_up_r4: assert property (@(posedge clk) disable iff (mreset)
        mode == 3'b011 |=> q == {$past(q[W-2:0]), $past(cet_sin_n)});

    p_count_up_r5: assert property (@(posedge clk) disable iff (mreset)
        (mode == 3'b110 && !cep_n && !cet_sin_n) |=> q == $past(q) + W'(1));

    p_count_dn_r5: assert property (@(posedge clk) disable iff (mreset)
        (mode == 3'b100 && !cep_n && !cet_sin_n) |=> q == $past(q) - W'(1));

    p_no_step_r6: assert property (@(posedge clk) disable iff (mreset)
        (mode[2] && !mode[0] && (cep_n || cet_sin_n)) |=> $stable(q));

    p_tc_idle_r7: assert property (@(posedge clk) disable iff (mreset)
        (mode[2] && !mode[0] && cet_sin_n) |-> tc_n);

    p_clear_r8: assert property (@(posedge clk) disable iff (mreset)
        mode == 3'b101 |=> q == '0);

    p_hold_r8: assert property (@(posedge clk) disable iff (mreset)
        mode == 3'b111 |=> $stable(q));

    p_tc_high_r8: assert property (@(posedge clk) disable iff (mreset)
        (mode[2] && mode[0]) |-> tc_n);

    // R9: q must be clear whenever the master reset is held.
    always @(negedge clk) begin
        if (mreset) begin
            p_mreset_r9: assert (q == '0);
        end
    end
endmodule

bind cnt_slice cnt_slice_chk #(.W(W)) u_chk (
    .clk(clk), .mreset(mreset), .mode(mode), .preset(preset),
    .cep_n(cep_n), .cet_sin_n(cet_sin_n), .sin_dn(sin_dn),
    .q(q), .tc_n(tc_n)
);

// File: tb/sim_cnt_slice.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_cnt_slice;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       mr;
    logic [2:0] md;
    logic [3:0] pre;
    logic       cep, cet, sdn;
    logic [3:0] q, qn;
    logic       tc;

    // Pair used for the cascade tests.
    logic [2:0] cmd;
    logic [7:0] cpre;
    logic       cin;
    logic [3:0] lq, lqn, hq, hqn;
    logic       ltc, htc;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    cnt_slice #(.W(4)) u0 (
        .clk(clk), .mreset(mr), .mode(md), .preset(pre), .cep_n(cep),
        .cet_sin_n(cet), .sin_dn(sdn), .q(q), .q_n(qn), .tc_n(tc)
    );

    cnt_slice #(.W(4)) u1 (
        .clk(clk), .mreset(mr), .mode(cmd), .preset(cpre[3:0]), .cep_n(1'b0),
        .cet_sin_n(cin), .sin_dn(1'b0), .q(lq), .q_n(lqn), .tc_n(ltc)
    );

    cnt_slice #(.W(4)) u2 (
        .clk(clk), .mreset(mr), .mode(cmd), .preset(cpre[7:4]), .cep_n(1'b0),
        .cet_sin_n(ltc), .sin_dn(1'b0), .q(hq), .q_n(hqn), .tc_n(htc)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One rising edge, ending at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [3:0] v);
        md = 3'b000; pre = v; step();
    endtask

    task automatic t_reset();
        chk("R9 reset q", q, 4'h0);
        chk("R10 reset q_n", qn, 4'hF);
    endtask

    task automatic t_load();
        md = 3'b000; pre = 4'hA; #1;
        chk("R1 tc_n low in load", tc, 1'b0);
        step();
        chk("R1 load q", q, 4'hA);
        chk("R10 q_n after load", qn, 4'h5);
    endtask

    task automatic t_invert();
        load(4'hA);
        md = 3'b001; #1;
        chk("R2 tc_n low in invert", tc, 1'b0);
        step();
        chk("R2 invert q", q, 4'h5);
        step();
        chk("R2 invert back", q, 4'hA);
    endtask

    task automatic t_shift_dn();
        load(4'hA);
        md = 3'b010; sdn = 1'b0; #1;
        chk("R3 tc_n follows sin_dn 0", tc, 1'b0);
        sdn = 1'b1; #1;
        chk("R3 tc_n follows sin_dn 1", tc, 1'b1);
        step();
        chk("R3 shift down in 1", q, 4'hD);
        sdn = 1'b0; step();
        chk("R3 shift down in 0", q, 4'h6);
    endtask

    task automatic t_shift_up();
        load(4'h3);
        md = 3'b011; cet = 1'b1; #1;
        chk("R4 tc_n is top bit 0", tc, 1'b0);
        step();
        chk("R4 shift up in 1", q, 4'h7);
        cet = 1'b0; step();
        chk("R4 shift up in 0", q, 4'hE);
        chk("R4 tc_n is top bit 1", tc, 1'b1);
    endtask

    task automatic t_count();
        cep = 1'b0; cet = 1'b0;
        load(4'hE);
        md = 3'b110; #1;
        chk("R7 up tc_n high below top", tc, 1'b1);
        step();
        chk("R5 count up", q, 4'hF);
        chk("R7 up tc_n low at top", tc, 1'b0);
        step();
        chk("R5 count up wraps", q, 4'h0);
        load(4'h1);
        md = 3'b100; #1;
        chk("R7 down tc_n high above zero", tc, 1'b1);
        step();
        chk("R5 count down", q, 4'h0);
        chk("R7 down tc_n low at zero", tc, 1'b0);
        step();
        chk("R5 count down wraps", q, 4'hF);
    endtask

    task automatic t_enables();
        load(4'hF);
        md = 3'b110; cep = 1'b1; cet = 1'b0; #1;
        chk("R7 tc_n low with cep high", tc, 1'b0);
        step();
        chk("R6 hold with cep high", q, 4'hF);
        cep = 1'b0; cet = 1'b1; #1;
        chk("R7 tc_n high with cet high", tc, 1'b1);
        step();
        chk("R6 hold with cet high", q, 4'hF);
        md = 3'b100; cep = 1'b1; cet = 1'b0; step();
        chk("R6 down hold with cep high", q, 4'hF);
        cep = 1'b0;
    endtask

    task automatic t_clear_hold();
        load(4'h9);
        md = 3'b111; #1;
        chk("R8 tc_n high in hold", tc, 1'b1);
        step();
        chk("R8 hold", q, 4'h9);
        md = 3'b101; #1;
        chk("R8 tc_n high in clear", tc, 1'b1);
        step();
        chk("R8 clear", q, 4'h0);
    endtask

    task automatic t_async();
        load(4'hC);
        #1 mr = 1'b1; #1;
        chk("R9 clear without edge", q, 4'h0);
        md = 3'b000; pre = 4'hF; step();
        chk("R9 overrides load", q, 4'h0);
        mr = 1'b0;
    endtask

    task automatic t_cascade_count();
        cin = 1'b0;
        cmd = 3'b000; cpre = 8'h3D; step();
        cmd = 3'b110;
        for (int k = 1; k <= 4; k++) begin
            step();
            chk("R11 cascade up", {hq, lq}, 8'h3D + 8'(k));
        end
        cmd = 3'b000; cpre = 8'hFF; step();
        cmd = 3'b110; step();
        chk("R11 cascade up wrap", {hq, lq}, 8'h00);
        cmd = 3'b000; cpre = 8'h42; step();
        cmd = 3'b100;
        for (int k = 1; k <= 4; k++) begin
            step();
            chk("R11 cascade down", {hq, lq}, 8'h42 - 8'(k));
        end
    endtask

    task automatic t_cascade_shift();
        logic [7:0] pat = 8'b1011_0010;
        logic [7:0] exp;
        cmd = 3'b000; cpre = 8'h00; step();
        exp = 8'h00;
        cmd = 3'b011;
        for (int k = 7; k >= 0; k--) begin
            cin = pat[k];
            step();
            exp = {exp[6:0], pat[k]};
            chk("R11 shift chain", {hq, lq}, exp);
        end
        chk("R11 shift chain full", {hq, lq}, pat);
    endtask

    initial begin
        mr = 1'b1; md = 3'b111; pre = '0; cep = 1'b0; cet = 1'b0; sdn = 1'b0;
        cmd = 3'b111; cpre = '0; cin = 1'b0;
        @(negedge clk);
        t_reset();
        @(negedge clk);
        mr = 1'b0;
        t_load();
        t_invert();
        t_shift_dn();
        t_shift_up();
        t_count();
        t_enables();
        t_clear_hold();
        t_async();
        t_cascade_count();
        t_cascade_shift();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule